// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Clear-to-Send Gating

This block is an asynchronous serial transmitter with two storage stages. The host writes a character into a holding register. A separate shift register sends frames on the serial line. A one-cycle clock enable at sixteen times the bit rate (the "tick") sets all timing. Each bit lasts sixteen ticks. A frame is one low start bit, eight data bits sent least-significant first, and one high stop bit. The line idles high.

The move of a character from the holding register into the shifter happens on fixed tick counts, and the buffer-empty flag reports it.
- From an idle shifter, the move takes four ticks after the write, and the start bit follows one tick later.
- While a frame is in flight, a waiting character moves across on the fifteenth tick of the stop bit. Its start bit replaces the sixteenth stop tick, so frames run with no gap.
- This back-to-back path is taken only if the buffer was full, and clear-to-send was active, when the twelfth stop-bit tick arrived. Otherwise the line goes idle and the character is loaded as a fresh one.

An active-low clear-to-send input holds back a waiting character. It is synchronised by one register.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset, buf_empty is 1 and tx is 1 (idle high).
- R2: With the shifter idle, buf_empty rises on the 4th tick after a write. A tick counts only if it falls in a later clock cycle than the write. buf_empty stays 0 for ticks 1 to 3.
- R3: With the shifter idle, tx drives the start bit (0) on the 5th tick after the write and stays 1 before it.
- R4: Frame format: start bit 0, then eight data bits with bit 0 first, then stop bit 1. Each bit lasts 16 ticks.
- R5: With a character waiting, buf_empty rises on the 15th tick of the stop bit of the running frame.
- R6: In that case the next start bit begins on the 16th tick of the stop bit, with no idle gap.
- R7: Cutoff for the back-to-back path. A write in a clock cycle before the 12th stop-bit tick is sent back to back. A later write lets the line idle after the stop bit. The character is then loaded fresh: buf_empty rises on the 4th tick after the stop bit ends, and the start bit comes on the 5th.
- R8: While cts_n is high (as seen at the 12th stop-bit tick, or at any time while the shifter is idle), a waiting character is not sent. buf_empty stays 0 and tx stays 1.
- R9: When cts_n goes low with a character waiting and the shifter idle, buf_empty rises on the 4th later tick and the start bit comes on the 5th.
- R10: A cts_n rise after the 12th stop-bit tick does not stop a character that is already eligible to go back to back.
- R11: A write while the buffer is full replaces the buffered character. The frame being shifted is not changed.
- R12: buf_empty falls only in the cycle after a write and rises only on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | One-cycle enable at 16x the bit rate |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_data | input | DATA_W (8) | Character to send |
| cts_n | input | 1 | Clear to send, active low |
| tx | output | 1 | Serial output, registered |
| buf_empty | output | 1 | Holding register empty, registered |

## Verification
Two events share a single tick on the back-to-back path: the end of one frame's stop bit and the start of the next frame. The bench places a write just before the twelfth stop tick and compares it with a write just after that tick. It checks tx and buf_empty at exact tick indices counted from the start bit. The clear-to-send test also meets this cutoff: cts_n rises one tick after the eligibility sample, and the pending character must still go out on the sixteenth stop tick. A scoreboard decodes every frame at mid-bit, so an overwrite or a corrupted shift shows up as a data mismatch.

// File: rtl/dbuf_tx_pkg.sv
package dbuf_tx_pkg;
  // launch sequencer: counting ticks toward a fresh load, or loaded and waiting to start
  typedef enum logic {
    LNCH_WAIT  = 1'b0,
    LNCH_ARMED = 1'b1
  } launch_e;
endpackage

// File: rtl/dbuf_tx_holdreg.sv
module dbuf_tx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              empty_o
);
  logic full_nxt;

  // a write in the same cycle as a take refills the register
  assign full_nxt = wr_en | (full_o & ~take);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      full_o  <= 1'b0;
      empty_o <= 1'b1;
    end else begin
      if (wr_en) data_o <= wr_data;
      full_o  <= full_nxt;
      empty_o <= ~full_nxt;
    end
  end
endmodule

// File: rtl/dbuf_tx_shifter.sv
module dbuf_tx_shifter #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              start,
  output logic              tx_o,
  output logic              active_o,
  output logic              in_stop_o,
  output logic [$clog2(OVS)-1:0] sub_o
);
  localparam int SUB_W    = $clog2(OVS);
  localparam int STOP_IDX = DATA_W + 1;
  localparam int IDX_W    = $clog2(STOP_IDX + 1);

  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;
  logic [SUB_W-1:0]  sub;

  assign sub_o     = sub;
  assign in_stop_o = active_o && (idx == IDX_W'(STOP_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      idx      <= '0;
      sub      <= '0;
      active_o <= 1'b0;
      tx_o     <= 1'b1;
    end else begin
      if (load) shreg <= load_data;
      if (start) begin
        active_o <= 1'b1;
        idx      <= '0;
        sub      <= '0;
        tx_o     <= 1'b0;
      end else if (active_o && tick) begin
        if (sub == SUB_W'(OVS - 1)) begin
          sub <= '0;
          if (idx == IDX_W'(STOP_IDX)) begin
            active_o <= 1'b0;
            tx_o     <= 1'b1;
          end else begin
            idx <= idx + IDX_W'(1);
            if (idx < IDX_W'(DATA_W)) begin
              tx_o  <= shreg[0];
              shreg <= shreg >> 1;
            end else begin
              tx_o <= 1'b1;
            end
          end
        end else begin
          sub <= sub + SUB_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dbuf_tx_launch.sv
module dbuf_tx_launch
  import dbuf_tx_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int CUT_TICK   = 12,
  parameter int FRESH_TAKE = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   buf_full,
  input  logic                   cts_ok,
  input  logic                   sh_active,
  input  logic                   sh_in_stop,
  input  logic [$clog2(OVS)-1:0] sh_sub,
  output logic                   take_o,
  output logic                   start_o
);
  localparam int SUB_W = $clog2(OVS);
  localparam int CNT_W = $clog2(FRESH_TAKE + 1);

  launch_e          st;
  logic [CNT_W-1:0] cnt;
  logic             elig;
  logic             at_cut, at_take, at_end, fresh_ok, fresh_take;

  assign at_cut     = tick && sh_in_stop && (sh_sub == SUB_W'(CUT_TICK - 1));
  assign at_take    = tick && sh_in_stop && (sh_sub == SUB_W'(OVS - 2));
  assign at_end     = tick && sh_in_stop && (sh_sub == SUB_W'(OVS - 1));
  assign fresh_ok   = buf_full && cts_ok && !sh_active;
  assign fresh_take = (st == LNCH_WAIT) && fresh_ok && tick
                      && (cnt == CNT_W'(FRESH_TAKE - 1));

  assign take_o  = (at_take && elig) || fresh_take;
  assign start_o = (at_end && elig) || ((st == LNCH_ARMED) && tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= LNCH_WAIT;
      cnt  <= '0;
      elig <= 1'b0;
    end else begin
      if (at_cut)      elig <= buf_full && cts_ok;
      else if (at_end) elig <= 1'b0;

      case (st)
        LNCH_WAIT: begin
          if (!fresh_ok) begin
            cnt <= '0;
          end else if (tick) begin
            if (fresh_take) begin
              cnt <= '0;
              st  <= LNCH_ARMED;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        default: begin
          if (tick) st <= LNCH_WAIT;
        end
      endcase
    end
  end
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
  parameter int DATA_W     = 8,
  parameter int OVS        = 16,
  parameter int CUT_TICK   = 12,
  parameter int FRESH_TAKE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_16x,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cts_n,
  output logic              tx,
  output logic              buf_empty
);
  localparam int SUB_W = $clog2(OVS);

  logic              cts_ok;
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              take, start;
  logic              sh_active, sh_in_stop;
  logic [SUB_W-1:0]  sh_sub;

  always_ff @(posedge clk) begin
    if (rst) cts_ok <= 1'b0;
    else     cts_ok <= ~cts_n;
  end

  dbuf_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .take(take),
    .data_o(buf_data), .full_o(buf_full), .empty_o(buf_empty)
  );

  dbuf_tx_launch #(.OVS(OVS), .CUT_TICK(CUT_TICK), .FRESH_TAKE(FRESH_TAKE)) u_launch (
    .clk(clk), .rst(rst), .tick(tick_16x), .buf_full(buf_full), .cts_ok(cts_ok),
    .sh_active(sh_active), .sh_in_stop(sh_in_stop), .sh_sub(sh_sub),
    .take_o(take), .start_o(start)
  );

  dbuf_tx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk(clk), .rst(rst), .tick(tick_16x), .load(take), .load_data(buf_data),
    .start(start), .tx_o(tx), .active_o(sh_active), .in_stop_o(sh_in_stop),
    .sub_o(sh_sub)
  );
endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic wr_en,
  input logic tx,
  input logic buf_empty,
  input logic active,
  input logic cts_ok
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (buf_empty && tx));

  assert_empty_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_empty) |-> $past(tick));

  assert_tx_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick) && !$past(rst)) |-> $stable(tx));

  assert_cts_gate_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_empty) |-> ($past(active) || $past(cts_ok)));

  assert_fill_after_write_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(buf_empty) |-> $past(wr_en));
endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick_16x), .wr_en(wr_en), .tx(tx),
  .buf_empty(buf_empty), .active(sh_active), .cts_ok(cts_ok)
);

// File: tb/dbuf_uart_tx_tb_top.sv
`timescale 1ns/1ps
module dbuf_uart_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_16x = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cts_n = 1'b0;
  logic       tx, buf_empty;

  int errors = 0;
  int checks = 0;
  int ntick  = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  dbuf_uart_tx dut_i (
    .clk(clk), .rst(rst), .tick_16x(tick_16x), .wr_en(wr_en), .wr_data(wr_data),
    .cts_n(cts_n), .tx(tx), .buf_empty(buf_empty)
  );

  always @(posedge clk) if (tick_16x) ntick = ntick + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (tick %0d)", req, act, exp, ntick);
    end
  endtask

  task automatic do_tick();
    tick_16x = 1'b1;
    @(negedge clk);
    tick_16x = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_to(input int t);
    while (ntick < t) do_tick();
  endtask

  // driver: writes a character and records whether it is expected on the line
  task automatic host_write(input logic [7:0] d, input bit expect_sent);
    wr_en = 1'b1;
    wr_data = d;
    if (expect_sent) exp_q.push_back(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cts(input logic v);
    cts_n = v;
    @(negedge clk);
  endtask

  // monitor: decode each frame at mid-bit and compare with the scoreboard
  logic       inf = 1'b0;
  int         t0 = 0;
  int         bi = 0;
  logic [7:0] got = 8'h00;
  logic [7:0] want;
  always @(negedge clk) begin
    if (!rst) begin
      if (!inf) begin
        if (tx == 1'b0) begin
          inf = 1'b1; t0 = ntick; bi = 0;
        end
      end else if (ntick == t0 + 8 + 16 * bi) begin
        if (bi == 0) chk("R4 start bit", int'(tx), 0);
        else if (bi <= 8) got[bi-1] = tx;
        else begin
          chk("R4 stop bit", int'(tx), 1);
          if (exp_q.size() == 0) chk("R4 R11 unexpected frame", int'(got), -1);
          else begin
            want = exp_q.pop_front();
            chk("R4 R11 frame data", int'(got), int'(want));
          end
          inf = 1'b0;
        end
        bi++;
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int w, s, c;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 buf_empty after reset", int'(buf_empty), 1);
    chk("R1 tx after reset", int'(tx), 1);

    // fresh load into an idle shifter
    w = ntick;
    host_write(8'h3C, 1);
    run_to(w + 3);
    chk("R2 buf_empty before 4th tick", int'(buf_empty), 0);
    chk("R3 tx before 5th tick", int'(tx), 1);
    run_to(w + 4);
    chk("R2 buf_empty on 4th tick", int'(buf_empty), 1);
    chk("R3 tx on 4th tick", int'(tx), 1);
    run_to(w + 5);
    chk("R3 start bit on 5th tick", int'(tx), 0);
    s = w + 5;

    // back to back with an early write
    run_to(s + 20);
    host_write(8'h96, 1);
    run_to(s + 158);
    chk("R5 buf_empty before 15th stop tick", int'(buf_empty), 0);
    run_to(s + 159);
    chk("R5 buf_empty on 15th stop tick", int'(buf_empty), 1);
    chk("R6 tx still stop on 15th", int'(tx), 1);
    run_to(s + 160);
    chk("R6 start bit on 16th stop tick", int'(tx), 0);
    s = s + 160;

    // late write: just after the 12th stop tick
    run_to(s + 156);
    host_write(8'h5A, 1);
    run_to(s + 159);
    chk("R7 late write no handoff", int'(buf_empty), 0);
    run_to(s + 160);
    chk("R7 line idles after stop", int'(tx), 1);
    run_to(s + 163);
    chk("R7 fresh load tick 3", int'(buf_empty), 0);
    run_to(s + 164);
    chk("R7 fresh load tick 4", int'(buf_empty), 1);
    run_to(s + 165);
    chk("R7 fresh start tick 5", int'(tx), 0);
    s = s + 165;

    // write just before the cutoff goes back to back
    run_to(s + 155);
    host_write(8'hE1, 1);
    run_to(s + 159);
    chk("R7 on-time write handoff", int'(buf_empty), 1);
    run_to(s + 160);
    chk("R7 on-time write start", int'(tx), 0);
    s = s + 160;

    // CTS held high blocks the waiting character
    run_to(s + 20);
    set_cts(1'b1);
    run_to(s + 30);
    host_write(8'hC3, 1);
    run_to(s + 160);
    chk("R8 blocked buf_empty", int'(buf_empty), 0);
    chk("R8 blocked tx", int'(tx), 1);
    run_to(s + 200);
    chk("R8 still blocked buf_empty", int'(buf_empty), 0);
    chk("R8 still blocked tx", int'(tx), 1);
    set_cts(1'b0);
    c = ntick;
    run_to(c + 3);
    chk("R9 buf_empty before 4th tick", int'(buf_empty), 0);
    run_to(c + 4);
    chk("R9 buf_empty on 4th tick", int'(buf_empty), 1);
    chk("R9 tx on 4th tick", int'(tx), 1);
    run_to(c + 5);
    chk("R9 start on 5th tick", int'(tx), 0);
    s = c + 5;

    // overwrite while full: only the last write is sent
    run_to(s + 10);
    host_write(8'h11, 0);
    run_to(s + 20);
    host_write(8'h22, 1);
    run_to(s + 160);
    chk("R11 replacement goes back to back", int'(tx), 0);
    s = s + 160;

    // CTS rises after the eligibility sample: still sent
    run_to(s + 30);
    host_write(8'h77, 1);
    run_to(s + 156);
    set_cts(1'b1);
    run_to(s + 159);
    chk("R10 handoff despite late CTS", int'(buf_empty), 1);
    run_to(s + 160);
    chk("R10 start despite late CTS", int'(tx), 0);
    set_cts(1'b0);
    s = s + 160;
    run_to(s + 170);
    chk("R4 all frames seen", exp_q.size(), 0);
    finish_run();
  end
endmodule